// File: doc/BRIEF.md
# Transmit-Empty Interrupt Generator

This block decides when a 16550-style serial port reports that its transmit path has room, and when it raises the transmit interrupt. It watches the occupancy of a 16-entry transmit FIFO and produces a transmit-empty status bit. It also keeps a pending-interrupt latch that CPU accesses clear. From these it forms the identification code the CPU reads.

When the FIFO drains after holding only one byte at a time, the empty status is held back. The hold lasts a programmed number of bit times, which is the frame length less the final stop bit, so that software is not woken while the last character is still being shifted. If the FIFO has held two or more bytes together since the status last went high, the status rises as soon as the FIFO is empty. Toggling FIFO mode while the status is high raises the interrupt at once.

The receive path supplies its own pending flag and code, which always take precedence over the transmit code. The serializer, the FIFO storage and the baud generator lie outside the block. The serializer delivers one `bit_tick_i` pulse per bit time.

Top module: `uart_txe_intgen`

## Requirements
- R1: Reset sets `thre_o` to 1, `tx_irq_o` to 0 and `iir_code_o` to 4'h1, and clears the two-byte tracking flag. After reset, a one-byte episode is therefore delayed.
- R2: One cycle after any cycle in which `fifo_empty_i` is 0, `thre_o` is 0.
- R3: If `fifo_count_i` was 2 or more at any cycle since `thre_o` last rose, `thre_o` rises on the first clock edge at which `fifo_empty_i` is 1.
- R4: Otherwise, `thre_o` rises on the edge of the `delay_bits_i`-th `bit_tick_i` counted while the FIFO is empty. With `delay_bits_i` = 0 it rises on the first empty edge. Ticks seen while the FIFO is non-empty are not counted.
- R5: The tracking flag clears each time `thre_o` rises, so a later one-byte episode is delayed again.
- R6: A rise of `thre_o` sets the pending latch. `tx_irq_o` shows the pending latch only while `fifo_mode_i` and `tx_int_en_i` are both 1. Gating does not discard a pending interrupt.
- R7: A `thr_wr_i` pulse clears the pending latch. `tx_irq_o` is 0 in the next cycle.
- R8: An `iir_rd_i` pulse clears the pending latch only while `iir_code_o` shows 4'h2. A read made while a receive code is shown leaves it pending.
- R9: A `fifo_mode_chg_i` pulse sets the pending latch if transmit-empty is high after that edge. The pulse has no effect while the FIFO holds data.
- R10: `iir_code_o` takes `rx_code_i` when `rx_pend_i` is 1. Otherwise it is 4'h2 when `tx_irq_o` is 1, and 4'h1 when nothing is pending.
- R11: Occupancies up to the full depth of 16 are accepted, and count toward the two-byte flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_mode_i | input | 1 | FIFO mode enabled (level) |
| tx_int_en_i | input | 1 | Transmit interrupt enable (level) |
| fifo_mode_chg_i | input | 1 | One-cycle pulse when FIFO mode is toggled |
| fifo_empty_i | input | 1 | Transmit FIFO is empty |
| fifo_count_i | input | 5 | Transmit FIFO occupancy, 0 to 16 |
| thr_wr_i | input | 1 | One-cycle pulse on a CPU write to the holding register |
| iir_rd_i | input | 1 | One-cycle pulse on a CPU read of the identification register |
| bit_tick_i | input | 1 | One pulse per serial bit time |
| delay_bits_i | input | 5 | Hold-back length in bit times (frame less last stop bit) |
| rx_pend_i | input | 1 | A receive-side interrupt is pending |
| rx_code_i | input | 4 | Identification code of the receive-side interrupt |
| thre_o | output | 1 | Transmit-empty status |
| tx_irq_o | output | 1 | Transmit interrupt request |
| iir_code_o | output | 4 | Identification code: 4'h1 none, 4'h2 transmit, else receive |

## Verification
Every output is a register loaded on the same edge that samples the causing input. A stimulus driven in one cycle is therefore visible exactly one edge later, whether it is a write, a read, a mode toggle, an occupancy change or a receive code. For the delayed case, the status rises one edge after the cycle carrying the final counted tick. The bench drives each vector at a falling edge and compares at the next falling edge, so a single rising edge lies between stimulus and observation. Tick sequences are laid out one vector per cycle, so the expected rise falls on a known row.

// File: rtl/uart_txe_pkg.sv
package uart_txe_pkg;

  localparam logic [3:0] IIR_NONE = 4'h1;
  localparam logic [3:0] IIR_TX   = 4'h2;

  typedef enum logic [1:0] {
    THRE_BUSY,
    THRE_HOLD,
    THRE_READY
  } thre_state_e;

endpackage

// File: rtl/uart_txe_occupancy.sv
module uart_txe_occupancy #(
  parameter int FIFO_DEPTH = 16,
  parameter int CNT_W      = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] fifo_count_i,
  input  logic             thre_rise_i,
  output logic             seen_two_o
);

  localparam logic [CNT_W-1:0] TWO  = CNT_W'(2);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FIFO_DEPTH);

  logic seen_q;

  // Flag records that two or more bytes sat in the FIFO together.
  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q <= 1'b0;
    end else if (thre_rise_i) begin
      seen_q <= 1'b0;
    end else if (fifo_count_i >= TWO) begin
      seen_q <= 1'b1;
    end
  end

  assign seen_two_o = seen_q;

  assert_count_range_R11: assert property (@(posedge clk) disable iff (rst)
    fifo_count_i <= FULL);

  assert_flag_after_rise_R5: assert property (@(posedge clk) disable iff (rst)
    (thre_rise_i && fifo_count_i < TWO) |=> !seen_q);

endmodule

// File: rtl/uart_txe_delay.sv
module uart_txe_delay #(
  parameter int DLY_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active_i,
  input  logic             bit_tick_i,
  input  logic [DLY_W-1:0] delay_bits_i,
  output logic             done_o
);

  logic [DLY_W-1:0] cnt_q;
  logic [DLY_W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + {{DLY_W{1'b0}}, 1'b1};

  // Counts bit times while the hold-back window is open.
  always_ff @(posedge clk) begin
    if (rst || !active_i) begin
      cnt_q <= '0;
    end else if (bit_tick_i && !done_o) begin
      cnt_q <= cnt_inc[DLY_W-1:0];
    end
  end

  always_comb begin
    done_o = 1'b0;
    if (active_i) begin
      if (delay_bits_i == '0) begin
        done_o = 1'b1;
      end else if (bit_tick_i && (cnt_inc >= {1'b0, delay_bits_i})) begin
        done_o = 1'b1;
      end
    end
  end

  assert_idle_cnt_R4: assert property (@(posedge clk) disable iff (rst)
    !active_i |=> (cnt_q == '0));

endmodule

// File: rtl/uart_txe_irq.sv
module uart_txe_irq (
  input  logic clk,
  input  logic rst,
  input  logic thre_rise_i,
  input  logic thre_next_i,
  input  logic fifo_mode_chg_i,
  input  logic thr_wr_i,
  input  logic iir_rd_i,
  input  logic shown_tx_i,
  output logic pend_next_o,
  output logic pend_o
);

  logic pend_q;
  logic do_set;
  logic do_clr;

  assign do_set = thre_rise_i || (fifo_mode_chg_i && thre_next_i);
  assign do_clr = thr_wr_i || (iir_rd_i && shown_tx_i);

  // Clearing accesses win over a set in the same cycle.
  always_comb begin
    pend_next_o = pend_q;
    if (do_clr) begin
      pend_next_o = 1'b0;
    end else if (do_set) begin
      pend_next_o = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
    end else begin
      pend_q <= pend_next_o;
    end
  end

  assign pend_o = pend_q;

  assert_read_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (iir_rd_i && shown_tx_i) |=> !pend_q);

  assert_mode_chg_sets_R9: assert property (@(posedge clk) disable iff (rst)
    (fifo_mode_chg_i && thre_next_i && !thr_wr_i && !iir_rd_i) |=> pend_q);

endmodule

// File: rtl/uart_txe_intgen.sv
module uart_txe_intgen
  import uart_txe_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int DLY_W      = 5,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fifo_mode_i,
  input  logic             tx_int_en_i,
  input  logic             fifo_mode_chg_i,
  input  logic             fifo_empty_i,
  input  logic [CNT_W-1:0] fifo_count_i,
  input  logic             thr_wr_i,
  input  logic             iir_rd_i,
  input  logic             bit_tick_i,
  input  logic [DLY_W-1:0] delay_bits_i,
  input  logic             rx_pend_i,
  input  logic [3:0]       rx_code_i,
  output logic             thre_o,
  output logic             tx_irq_o,
  output logic [3:0]       iir_code_o
);

  logic        thre_q;
  logic        thre_next;
  logic        thre_rise;
  logic        seen_two;
  logic        hold_active;
  logic        hold_done;
  logic        pend_next;
  logic        pend_q;
  logic        shown_tx;
  logic        irq_next;
  logic        irq_q;
  logic [3:0]  iir_q;
  thre_state_e state;

  // Classification of the current empty situation.
  always_comb begin
    if (!fifo_empty_i) begin
      state = THRE_BUSY;
    end else if (thre_q || seen_two) begin
      state = THRE_READY;
    end else begin
      state = THRE_HOLD;
    end
  end

  assign hold_active = (state == THRE_HOLD);

  always_comb begin
    unique case (state)
      THRE_BUSY:  thre_next = 1'b0;
      THRE_READY: thre_next = 1'b1;
      THRE_HOLD:  thre_next = hold_done;
      default:    thre_next = 1'b0;
    endcase
  end

  assign thre_rise = thre_next && !thre_q;

  uart_txe_occupancy #(
    .FIFO_DEPTH (FIFO_DEPTH),
    .CNT_W      (CNT_W)
  ) i_occupancy (
    .clk          (clk),
    .rst          (rst),
    .fifo_count_i (fifo_count_i),
    .thre_rise_i  (thre_rise),
    .seen_two_o   (seen_two)
  );

  uart_txe_delay #(
    .DLY_W (DLY_W)
  ) i_delay (
    .clk          (clk),
    .rst          (rst),
    .active_i     (hold_active),
    .bit_tick_i   (bit_tick_i),
    .delay_bits_i (delay_bits_i),
    .done_o       (hold_done)
  );

  assign shown_tx = (iir_q == IIR_TX);

  uart_txe_irq i_irq (
    .clk             (clk),
    .rst             (rst),
    .thre_rise_i     (thre_rise),
    .thre_next_i     (thre_next),
    .fifo_mode_chg_i (fifo_mode_chg_i),
    .thr_wr_i        (thr_wr_i),
    .iir_rd_i        (iir_rd_i),
    .shown_tx_i      (shown_tx),
    .pend_next_o     (pend_next),
    .pend_o          (pend_q)
  );

  assign irq_next = pend_next && fifo_mode_i && tx_int_en_i;

  // Registered outputs, all loaded on the same edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      thre_q <= 1'b1;
      irq_q  <= 1'b0;
      iir_q  <= IIR_NONE;
    end else begin
      thre_q <= thre_next;
      irq_q  <= irq_next;
      if (rx_pend_i) begin
        iir_q <= rx_code_i;
      end else if (irq_next) begin
        iir_q <= IIR_TX;
      end else begin
        iir_q <= IIR_NONE;
      end
    end
  end

  assign thre_o     = thre_q;
  assign tx_irq_o   = irq_q;
  assign iir_code_o = iir_q;

  assert_irq_gated_R6: assert property (@(posedge clk) disable iff (rst)
    tx_irq_o |-> $past(fifo_mode_i && tx_int_en_i));

  assert_irq_needs_pend_R6: assert property (@(posedge clk) disable iff (rst)
    tx_irq_o |-> pend_q);

  assert_nonempty_clears_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(!fifo_empty_i)) |-> !thre_o);

  assert_write_clears_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(thr_wr_i)) |-> !tx_irq_o);

  assert_rx_priority_R10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(rx_pend_i)) |-> (iir_code_o == $past(rx_code_i)));

  assert_fast_empty_R3: assert property (@(posedge clk) disable iff (rst)
    (fifo_empty_i && seen_two) |=> thre_o);

endmodule

// File: tb/test_uart_txe_intgen.sv
module test_uart_txe_intgen;

  localparam int NV = 24;

  // {empty, count[4:0], wr, rd, tick, chg, rxp, rxc[3:0], e_thre, e_irq, e_iir[3:0], req[3:0]}
  localparam logic [24:0] VEC [NV] = '{
    {1'b1, 5'd0,  1'b0,1'b0,1'b0,1'b0, 1'b0,4'h0, 1'b1,1'b0,4'h1, 4'd1},  // R1 idle
    {1'b1, 5'd0,  1'b0,1'b0,1'b0,1'b1, 1'b0,4'h0, 1'b1,1'b1,4'h2, 4'd9},  // R9 toggle
    {1'b1, 5'd0,  1'b0,1'b1,1'b0,1'b0, 1'b0,4'h0, 1'b1,1'b0,4'h1, 4'd8},  // R8 read
    {1'b0, 5'd1,  1'b1,1'b0,1'b0,1'b0, 1'b0,4'h0, 1'b0,1'b0,4'h1, 4'd2},  // R2 write
    {1'b0, 5'd1,  1'b0,1'b0,1'b1,1'b0, 1'b0,4'h0, 1'b0,1'b0,4'h1, 4'd4},  // R4 tick ignored
    {1'b1, 5'd0,  1'b0,1'b0,1'b0,1'b0, 1'b0,4'h0, 1'b0,1'b0,4'h1, 4'd4},  // R4 hold
    {1'b1, 5'd0,  1'b0,1'b0,1'b1,1'b0, 1'b0,4'h0, 1'b0,1'b0,4'h1, 4'd4},
    {1'b1, 5'd0,  1'b0,1'b0,1'b1,1'b0, 1'b0,4'h0, 1'b0,1'b0,4'h1, 4'd4},
    {1'b1, 5'd0,  1'b0,1'b0,1'b0,1'b0, 1'b0,4'h0, 1'b0,1'b0,4'h1, 4'd4},
    {1'b1, 5'd0,  1'b0,1'b0,1'b1,1'b0, 1'b0,4'h0, 1'b1,1'b1,4'h2, 4'd4},  // R4 third tick
    {1'b1, 5'd0,  1'b0,1'b0,1'b0,1'b0, 1'b1,4'h6, 1'b1,1'b1,4'h6, 4'd10}, // R10 rx first
    {1'b1, 5'd0,  1'b0,1'b1,1'b0,1'b0, 1'b1,4'h6, 1'b1,1'b1,4'h6, 4'd8},  // R8 read under rx
    {1'b1, 5'd0,  1'b0,1'b0,1'b0,1'b0, 1'b0,4'h0, 1'b1,1'b1,4'h2, 4'd10},
    {1'b0, 5'd1,  1'b1,1'b0,1'b0,1'b0, 1'b0,4'h0, 1'b0,1'b0,4'h1, 4'd7},  // R7 write
    {1'b0, 5'd2,  1'b0,1'b0,1'b0,1'b0, 1'b0,4'h0, 1'b0,1'b0,4'h1, 4'd3},
    {1'b0, 5'd1,  1'b0,1'b0,1'b1,1'b0, 1'b0,4'h0, 1'b0,1'b0,4'h1, 4'd3},
    {1'b1, 5'd0,  1'b0,1'b0,1'b0,1'b0, 1'b0,4'h0, 1'b1,1'b1,4'h2, 4'd3},  // R3 fast
    {1'b0, 5'd1,  1'b1,1'b0,1'b0,1'b0, 1'b0,4'h0, 1'b0,1'b0,4'h1, 4'd7},
    {1'b1, 5'd0,  1'b0,1'b0,1'b0,1'b0, 1'b0,4'h0, 1'b0,1'b0,4'h1, 4'd5},  // R5 delayed again
    {1'b1, 5'd0,  1'b0,1'b0,1'b1,1'b0, 1'b0,4'h0, 1'b0,1'b0,4'h1, 4'd5},
    {1'b1, 5'd0,  1'b0,1'b0,1'b1,1'b0, 1'b0,4'h0, 1'b0,1'b0,4'h1, 4'd5},
    {1'b1, 5'd0,  1'b0,1'b0,1'b1,1'b0, 1'b0,4'h0, 1'b1,1'b1,4'h2, 4'd5},
    {1'b0, 5'd16, 1'b1,1'b0,1'b0,1'b0, 1'b0,4'h0, 1'b0,1'b0,4'h1, 4'd11}, // R11 full
    {1'b1, 5'd0,  1'b0,1'b0,1'b0,1'b0, 1'b0,4'h0, 1'b1,1'b1,4'h2, 4'd11}
  };

  logic       clk = 1'b0;
  logic       rst;
  logic       fifo_mode_i, tx_int_en_i, fifo_mode_chg_i, fifo_empty_i;
  logic [4:0] fifo_count_i;
  logic       thr_wr_i, iir_rd_i, bit_tick_i;
  logic [4:0] delay_bits_i;
  logic       rx_pend_i;
  logic [3:0] rx_code_i;
  logic       thre_o, tx_irq_o;
  logic [3:0] iir_code_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  uart_txe_intgen i_uart_txe_intgen (
    .clk (clk), .rst (rst),
    .fifo_mode_i (fifo_mode_i), .tx_int_en_i (tx_int_en_i),
    .fifo_mode_chg_i (fifo_mode_chg_i), .fifo_empty_i (fifo_empty_i),
    .fifo_count_i (fifo_count_i), .thr_wr_i (thr_wr_i), .iir_rd_i (iir_rd_i),
    .bit_tick_i (bit_tick_i), .delay_bits_i (delay_bits_i),
    .rx_pend_i (rx_pend_i), .rx_code_i (rx_code_i),
    .thre_o (thre_o), .tx_irq_o (tx_irq_o), .iir_code_o (iir_code_o)
  );

  task automatic check(input string req, input logic e_thre, input logic e_irq,
                       input logic [3:0] e_iir);
    checks++;
    if (thre_o !== e_thre || tx_irq_o !== e_irq || iir_code_o !== e_iir) begin
      errors++;
      $display("FAIL %s: thre/irq/iir actual %b/%b/%h expected %b/%b/%h",
               req, thre_o, tx_irq_o, iir_code_o, e_thre, e_irq, e_iir);
    end
  endtask

  task automatic idle();
    fifo_mode_chg_i = 1'b0; thr_wr_i = 1'b0; iir_rd_i = 1'b0;
    bit_tick_i = 1'b0; rx_pend_i = 1'b0; rx_code_i = 4'h0;
  endtask

  task automatic drive(input logic empty, input logic [4:0] cnt, input logic wr,
                       input logic tick, input logic chg);
    idle();
    fifo_empty_i = empty; fifo_count_i = cnt; thr_wr_i = wr;
    bit_tick_i = tick; fifo_mode_chg_i = chg;
    @(negedge clk);
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    rst = 1'b1; idle();
    fifo_mode_i = 1'b1; tx_int_en_i = 1'b1; delay_bits_i = 5'd3;
    fifo_empty_i = 1'b0; fifo_count_i = 5'd0;
    repeat (3) @(negedge clk);
    check("R1 in reset", 1'b1, 1'b0, 4'h1);
    rst = 1'b0; fifo_empty_i = 1'b1;

    for (int i = 0; i < NV; i++) begin
      idle();
      fifo_empty_i    = VEC[i][24];
      fifo_count_i    = VEC[i][23:19];
      thr_wr_i        = VEC[i][18];
      iir_rd_i        = VEC[i][17];
      bit_tick_i      = VEC[i][16];
      fifo_mode_chg_i = VEC[i][15];
      rx_pend_i       = VEC[i][14];
      rx_code_i       = VEC[i][13:10];
      @(negedge clk);
      check($sformatf("R%0d vector %0d", VEC[i][3:0], i), VEC[i][9], VEC[i][8], VEC[i][7:4]);
    end

    // R6: gating hides but keeps the pending interrupt
    idle(); tx_int_en_i = 1'b0; @(negedge clk);
    check("R6 enable off", 1'b1, 1'b0, 4'h1);
    tx_int_en_i = 1'b1; @(negedge clk);
    check("R6 enable back", 1'b1, 1'b1, 4'h2);
    fifo_mode_i = 1'b0; @(negedge clk);
    check("R6 fifo mode off", 1'b1, 1'b0, 4'h1);
    fifo_mode_i = 1'b1; @(negedge clk);
    check("R6 fifo mode back", 1'b1, 1'b1, 4'h2);

    // R9: toggle while FIFO holds data has no effect
    drive(1'b0, 5'd1, 1'b1, 1'b0, 1'b0);
    check("R7 write clears", 1'b0, 1'b0, 4'h1);
    drive(1'b0, 5'd1, 1'b0, 1'b0, 1'b1);
    check("R9 toggle while busy", 1'b0, 1'b0, 4'h1);

    // R4: zero hold-back rises on first empty edge
    delay_bits_i = 5'd0;
    drive(1'b1, 5'd0, 1'b0, 1'b0, 1'b0);
    check("R4 zero delay", 1'b1, 1'b1, 4'h2);
    delay_bits_i = 5'd3;

    // R1: reset mid-operation clears pending and tracking flag
    drive(1'b0, 5'd2, 1'b1, 1'b0, 1'b0);
    check("R7 write before reset", 1'b0, 1'b0, 4'h1);
    rst = 1'b1;
    drive(1'b0, 5'd2, 1'b0, 1'b0, 1'b0);
    check("R1 reset mid-run", 1'b1, 1'b0, 4'h1);
    rst = 1'b0;
    drive(1'b1, 5'd0, 1'b0, 1'b0, 1'b0);
    check("R1 no interrupt after reset", 1'b1, 1'b0, 4'h1);
    drive(1'b0, 5'd1, 1'b1, 1'b0, 1'b0);
    check("R2 busy after reset", 1'b0, 1'b0, 4'h1);
    drive(1'b1, 5'd0, 1'b0, 1'b0, 1'b0);
    check("R1 flag cleared by reset", 1'b0, 1'b0, 4'h1);
    drive(1'b1, 5'd0, 1'b0, 1'b1, 1'b0);
    drive(1'b1, 5'd0, 1'b0, 1'b1, 1'b0);
    check("R4 two ticks", 1'b0, 1'b0, 4'h1);
    drive(1'b1, 5'd0, 1'b0, 1'b1, 1'b0);
    check("R4 third tick", 1'b1, 1'b1, 4'h2);

    // R8: read with transmit code shown clears
    idle(); iir_rd_i = 1'b1; @(negedge clk);
    check("R8 read clears", 1'b1, 1'b0, 4'h1);
    idle(); @(negedge clk);
    check("R8 stays clear", 1'b1, 1'b0, 4'h1);

    done = 1'b1;
    report();
  end

endmodule